// File: doc/BRIEF.md
# Segment Selector Address Translator

This block converts a logical address, made of a 16-bit segment selector and a 32-bit offset, into a 32-bit linear address. The selector does not hold a segment address. It carries a table index, a bit that picks one of two on-chip descriptor tables (global or local), and a requested privilege level. The chosen descriptor supplies a base, an inclusive byte limit, a type/access byte and a descriptor privilege level. Each access is checked for a null selector, a missing entry, privilege, access type and limit. Only after all five checks pass is the base added to the offset.

Requests use a valid/ready handshake. The request carries the selector, the offset, an access kind and the current privilege level. The result appears one cycle later as a response with a fault flag and a fault code. Software fills the tables through a synchronous write port.

A two-state response machine controls the output. In `RSP_IDLE` no result is presented. An accepted request moves it to `RSP_LIVE` (transition *accept*). In `RSP_LIVE` another accepted request keeps it there (transition *stream*). A cycle with no request returns it to `RSP_IDLE` (transition *drain*).

Top module: `seg_xlate`

## Requirements
- R1: Selector bits [15:3] are the table index, bit 2 selects the table (0 global, 1 local), and bits [1:0] are the requested privilege level (RPL).
- R2: A global selector with index 0 faults with code 1 (null) whatever its RPL. Local index 0 is an ordinary entry.
- R3: An entry whose type bit 7 (present) is clear, or an index at or beyond `DEPTH`, faults with code 2 (absent). Reset clears every entry to absent.
- R4: When the larger of the current privilege level (CPL) and the RPL is numerically above the descriptor's privilege level, the access faults with code 5 (privilege).
- R5: Access kinds are 0 read, 1 write, 2 execute and 3 reserved. The access faults with code 4 (type) in any of these cases: type bit 4 is clear (system entry); the kind is reserved; the kind is execute and bit 3 (executable) is clear; the kind is write and either bit 3 is set or bit 1 (writable/readable) is clear; the kind is read of an executable entry with bit 1 clear.
- R6: An offset strictly greater than the inclusive limit faults with code 3 (limit). The offset alone is compared; the base plays no part.
- R7: When several faults apply, the reported code follows the priority null, absent, privilege, type, limit.
- R8: Without a fault, the linear address is base plus offset modulo 2^32, and wrapping is not a fault. With a fault, the linear address is 0 and the fault flag is 1. The flag is 1 exactly when the code is non-zero.
- R9: `req_ready` is always high. `resp_valid` is high in the cycle after each accepted request and low after any cycle without one.
- R10: A table write takes effect at the clock edge. A translation in the same cycle as a write to its entry sees the old contents, and the next translation sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request can be taken |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_cpl | input | 2 | Current privilege level |
| resp_valid | output | 1 | Result presented |
| resp_lin | output | 32 | Linear address, 0 on fault |
| resp_fault | output | 1 | Fault raised |
| resp_code | output | 3 | 0 none, 1 null, 2 absent, 3 limit, 4 type, 5 privilege |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | 0 global table, 1 local table |
| wr_idx | input | $clog2(DEPTH) | Entry written |
| wr_base | input | 32 | Segment base |
| wr_limit | input | 32 | Inclusive segment limit |
| wr_type | input | 8 | Type/access byte |
| wr_dpl | input | 2 | Descriptor privilege level |

## Verification
The hardest case to reach from the ports is a write and a translation landing on the same entry in the same cycle. The bench produces it by driving the write strobe and a request on the same falling edge, so the rising edge that stores the entry is also the edge that registers the response. Fault priority is the other hard area. The bench uses descriptors that break several rules at once, for example a code segment that is out of privilege, written to and past its limit, and then lifts one violation at a time to expose each rank.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] limit;
        logic [7:0]  atype;
        logic [1:0]  dpl;
    } seg_desc_t;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_NULL   = 3'd1,
        FLT_ABSENT = 3'd2,
        FLT_LIMIT  = 3'd3,
        FLT_TYPE   = 3'd4,
        FLT_PRIV   = 3'd5
    } fault_e;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_LIVE = 1'b1
    } rsp_state_e;

    // Type byte bit positions
    localparam int TB_PRESENT = 7;
    localparam int TB_NONSYS  = 4;
    localparam int TB_EXEC    = 3;
    localparam int TB_RW      = 1;

    function automatic logic type_violation(input logic [7:0] t, input acc_e a);
        logic bad;
        if (!t[TB_NONSYS]) begin
            bad = 1'b1;
        end else begin
            unique case (a)
                ACC_RD:  bad = t[TB_EXEC] && !t[TB_RW];
                ACC_WR:  bad = t[TB_EXEC] || !t[TB_RW];
                ACC_EX:  bad = !t[TB_EXEC];
                default: bad = 1'b1;
            endcase
        end
        return bad;
    endfunction

    function automatic logic [1:0] eff_priv(input logic [1:0] cpl, input logic [1:0] rpl);
        return (cpl > rpl) ? cpl : rpl;
    endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
    import seg_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  seg_desc_t        wdata,
    input  logic [IDX_W-1:0] ridx,
    output seg_desc_t        rdata
);

    seg_desc_t mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Read before write: a same-cycle write lands at the edge.
    always_comb begin
        rdata = mem[ridx];
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
(
    input  seg_desc_t   desc,
    input  logic        is_null,
    input  logic        in_range,
    input  logic [1:0]  rpl,
    input  logic [1:0]  cpl,
    input  acc_e        acc,
    input  logic [31:0] offset,
    output fault_e      code,
    output logic [31:0] lin
);

    logic present;
    logic priv_bad;
    logic type_bad;
    logic limit_bad;

    always_comb begin
        present   = desc.atype[TB_PRESENT] && in_range;
        priv_bad  = eff_priv(cpl, rpl) > desc.dpl;
        type_bad  = type_violation(desc.atype, acc);
        limit_bad = offset > desc.limit;
        lin       = desc.base + offset;

        if (is_null) begin
            code = FLT_NULL;
        end else if (!present) begin
            code = FLT_ABSENT;
        end else if (priv_bad) begin
            code = FLT_PRIV;
        end else if (type_bad) begin
            code = FLT_TYPE;
        end else if (limit_bad) begin
            code = FLT_LIMIT;
        end else begin
            code = FLT_NONE;
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SEL_IDX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [15:0]      req_sel,
    input  logic [31:0]      req_off,
    input  logic [1:0]       req_acc,
    input  logic [1:0]       req_cpl,
    output logic             resp_valid,
    output logic [31:0]      resp_lin,
    output logic             resp_fault,
    output logic [2:0]       resp_code,
    input  logic             wr_en,
    input  logic             wr_tbl,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_base,
    input  logic [31:0]      wr_limit,
    input  logic [7:0]       wr_type,
    input  logic [1:0]       wr_dpl
);

    // Selector fields
    logic [SEL_IDX_W-1:0] sel_idx;
    logic                 sel_ti;
    logic [1:0]           sel_rpl;
    logic                 sel_null;
    logic                 sel_in_range;

    always_comb begin
        sel_idx      = req_sel[15:3];
        sel_ti       = req_sel[2];
        sel_rpl      = req_sel[1:0];
        sel_null     = !sel_ti && (sel_idx == '0);
        sel_in_range = {1'b0, sel_idx} < (SEL_IDX_W+1)'(DEPTH);
    end

    // Descriptor tables: 0 global, 1 local
    seg_desc_t wdesc;
    seg_desc_t rdesc [2];
    seg_desc_t cur_desc;

    always_comb begin
        wdesc.base  = wr_base;
        wdesc.limit = wr_limit;
        wdesc.atype = wr_type;
        wdesc.dpl   = wr_dpl;
    end

    for (genvar g = 0; g < 2; g++) begin : g_tbl
        seg_desc_table #(.DEPTH(DEPTH)) u_tbl (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && (wr_tbl == 1'(g))),
            .widx  (wr_idx),
            .wdata (wdesc),
            .ridx  (sel_idx[IDX_W-1:0]),
            .rdata (rdesc[g])
        );
    end

    always_comb begin
        cur_desc = sel_ti ? rdesc[1] : rdesc[0];
    end

    // Checks and base addition
    fault_e      chk_code;
    logic [31:0] chk_lin;

    seg_check u_check (
        .desc     (cur_desc),
        .is_null  (sel_null),
        .in_range (sel_in_range),
        .rpl      (sel_rpl),
        .cpl      (req_cpl),
        .acc      (acc_e'(req_acc)),
        .offset   (req_off),
        .code     (chk_code),
        .lin      (chk_lin)
    );

    // Response state machine
    rsp_state_e state_q, state_d;
    logic       accept;
    fault_e     code_q;
    logic       fault_q;
    logic [31:0] lin_q;

    always_comb begin
        accept = req_valid && req_ready;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSP_IDLE: if (accept)  state_d = RSP_LIVE;
            RSP_LIVE: if (!accept) state_d = RSP_IDLE;
            default:               state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= FLT_NONE;
            fault_q <= 1'b0;
            lin_q   <= '0;
        end else if (accept) begin
            code_q  <= chk_code;
            fault_q <= (chk_code != FLT_NONE);
            lin_q   <= (chk_code == FLT_NONE) ? chk_lin : 32'd0;
        end
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b1;
        resp_valid = (state_q == RSP_LIVE);
        resp_code  = code_q;
        resp_fault = fault_q;
        resp_lin   = lin_q;
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [15:0] req_sel,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic [2:0]  resp_code,
    input logic [31:0] resp_lin
);

    a_r9_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready);

    a_r9_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !resp_valid);

    a_r2_null_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_sel[15:2] == 14'd0) |=> (resp_fault && resp_code == 3'd1));

    a_r8_fault_zero_lin: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_lin == 32'd0));

    a_r8_flag_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_fault == (resp_code != 3'd0)));

    a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_code <= 3'd5));

endmodule

bind seg_xlate seg_xlate_chk u_seg_xlate_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_sel    (req_sel),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_code  (resp_code),
    .resp_lin   (resp_lin)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

    localparam int DEPTH = 16;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [15:0]      req_sel = '0;
    logic [31:0]      req_off = '0;
    logic [1:0]       req_acc = '0;
    logic [1:0]       req_cpl = '0;
    logic             resp_valid;
    logic [31:0]      resp_lin;
    logic             resp_fault;
    logic [2:0]       resp_code;
    logic             wr_en = 1'b0;
    logic             wr_tbl = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [31:0]      wr_base = '0;
    logic [31:0]      wr_limit = '0;
    logic [7:0]       wr_type = '0;
    logic [1:0]       wr_dpl = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_xlate #(.DEPTH(DEPTH)) i_seg_xlate (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic load(input logic tbl, input int idx, input logic [31:0] base,
                        input logic [31:0] lim, input logic [7:0] typ, input logic [1:0] dpl);
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = tbl; wr_idx = IDX_W'(idx);
        wr_base = base; wr_limit = lim; wr_type = typ; wr_dpl = dpl;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // Drive one request, sample the registered response after the edge.
    task automatic xl(input string req, input logic [15:0] sel, input logic [31:0] off,
                      input logic [1:0] acc, input logic [1:0] cpl,
                      input logic [2:0] exp_code, input logic [31:0] exp_lin);
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_off = off; req_acc = acc; req_cpl = cpl;
        @(posedge clk);
        #1;
        check(req, "resp_valid", 32'(resp_valid), 32'd1);
        check(req, "resp_code", 32'(resp_code), 32'(exp_code));
        check(req, "resp_fault", 32'(resp_fault), 32'(exp_code != 3'd0));
        check(req, "resp_lin", resp_lin, exp_lin);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R9", "reset resp_valid", 32'(resp_valid), 32'd0);
        check("R9", "reset req_ready", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        // R3: tables clear after reset, so any real entry is absent
        xl("R3", 16'h0010, 32'h0, 2'd0, 2'd0, 3'd2, 32'h0);
    endtask

    task automatic t_setup;
        load(1'b0, 1,  32'h0000_0000, 32'hFFFF_FFFF, 8'h9A, 2'd0);
        load(1'b0, 2,  32'h0000_0000, 32'hFFFF_FFFF, 8'h92, 2'd0);
        load(1'b0, 3,  32'hF000_0000, 32'hFFFF_FFFF, 8'h92, 2'd3);
        load(1'b0, 4,  32'h0000_1000, 32'h0000_00FF, 8'h92, 2'd3);
        load(1'b0, 6,  32'h0000_0000, 32'h0000_FFFF, 8'h92, 2'd1);
        load(1'b0, 7,  32'h0000_0000, 32'h0000_000F, 8'h9A, 2'd2);
        load(1'b0, 8,  32'h0000_0000, 32'h0000_FFFF, 8'h90, 2'd3);
        load(1'b0, 9,  32'h0000_0000, 32'h0000_FFFF, 8'h12, 2'd3);
        load(1'b0, 10, 32'h0000_0000, 32'h0000_FFFF, 8'h82, 2'd3);
        load(1'b0, 11, 32'h0000_0000, 32'h0000_FFFF, 8'h12, 2'd0);
        load(1'b1, 0,  32'h0000_5000, 32'h0000_0FFF, 8'h92, 2'd3);
        load(1'b1, 1,  32'h0000_8000, 32'h0000_FFFF, 8'h92, 2'd3);
    endtask

    task automatic t_null;
        xl("R2", 16'h0000, 32'h10, 2'd0, 2'd0, 3'd1, 32'h0);
        xl("R2", 16'h0003, 32'h10, 2'd1, 2'd3, 3'd1, 32'h0);
    endtask

    task automatic t_flat;
        xl("R8", 16'h0010, 32'h0000_1234, 2'd0, 2'd0, 3'd0, 32'h0000_1234);
        xl("R8", 16'h0008, 32'h0000_0400, 2'd2, 2'd0, 3'd0, 32'h0000_0400);
        xl("R5", 16'h0008, 32'h0000_0800, 2'd0, 2'd0, 3'd0, 32'h0000_0800);
    endtask

    task automatic t_wrap;
        xl("R8", 16'h001B, 32'h2000_0000, 2'd1, 2'd3, 3'd0, 32'h1000_0000);
        xl("R8", 16'h001B, 32'h0000_0000, 2'd0, 2'd3, 3'd0, 32'hF000_0000);
    endtask

    task automatic t_limit;
        xl("R6", 16'h0023, 32'h0000_00FF, 2'd1, 2'd3, 3'd0, 32'h0000_10FF);
        xl("R6", 16'h0023, 32'h0000_0100, 2'd1, 2'd3, 3'd3, 32'h0);
        xl("R6", 16'h0023, 32'hFFFF_FFFF, 2'd0, 2'd3, 3'd3, 32'h0);
    endtask

    task automatic t_absent;
        xl("R3", 16'h002B, 32'h0, 2'd0, 2'd3, 3'd2, 32'h0);
        xl("R3", 16'h00A3, 32'h0, 2'd0, 2'd3, 3'd2, 32'h0);
        xl("R3", 16'h004B, 32'h0, 2'd0, 2'd3, 3'd2, 32'h0);
    endtask

    task automatic t_type;
        xl("R5", 16'h0008, 32'h0, 2'd1, 2'd0, 3'd4, 32'h0);
        xl("R5", 16'h0010, 32'h0, 2'd2, 2'd0, 3'd4, 32'h0);
        xl("R5", 16'h0043, 32'h0, 2'd1, 2'd3, 3'd4, 32'h0);
        xl("R5", 16'h0043, 32'h77, 2'd0, 2'd3, 3'd0, 32'h77);
        xl("R5", 16'h0053, 32'h0, 2'd0, 2'd3, 3'd4, 32'h0);
        xl("R5", 16'h0010, 32'h0, 2'd3, 2'd0, 3'd4, 32'h0);
    endtask

    task automatic t_priv;
        xl("R4", 16'h0030, 32'h0, 2'd0, 2'd2, 3'd5, 32'h0);
        xl("R4", 16'h0032, 32'h0, 2'd0, 2'd0, 3'd5, 32'h0);
        xl("R4", 16'h0031, 32'h40, 2'd0, 2'd1, 3'd0, 32'h40);
        xl("R4", 16'h0030, 32'h44, 2'd1, 2'd0, 3'd0, 32'h44);
    endtask

    task automatic t_local;
        // R1: TI=1 picks the local table; local index 0 is not null
        xl("R1", 16'h0004, 32'h10, 2'd0, 2'd0, 3'd0, 32'h5010);
        xl("R2", 16'h0007, 32'h20, 2'd1, 2'd3, 3'd0, 32'h5020);
        xl("R1", 16'h000C, 32'h4, 2'd0, 2'd0, 3'd0, 32'h8004);
        xl("R1", 16'h0014, 32'h0, 2'd0, 2'd0, 3'd2, 32'h0);
    endtask

    task automatic t_priority;
        xl("R7", 16'h0003, 32'hFFFF_FFFF, 2'd1, 2'd3, 3'd1, 32'h0);
        xl("R7", 16'h005B, 32'h0, 2'd0, 2'd3, 3'd2, 32'h0);
        xl("R7", 16'h003B, 32'h100, 2'd1, 2'd3, 3'd5, 32'h0);
        xl("R7", 16'h003A, 32'h100, 2'd1, 2'd2, 3'd4, 32'h0);
        xl("R7", 16'h003A, 32'h100, 2'd0, 2'd2, 3'd3, 32'h0);
    endtask

    task automatic t_collide;
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = 1'b0; wr_idx = IDX_W'(3);
        wr_base = 32'h0000_0100; wr_limit = 32'hFFFF_FFFF; wr_type = 8'h92; wr_dpl = 2'd3;
        req_valid = 1'b1; req_sel = 16'h0018; req_off = 32'h5; req_acc = 2'd0; req_cpl = 2'd0;
        @(posedge clk);
        #1;
        check("R10", "old entry seen", resp_lin, 32'hF000_0005);
        wr_en = 1'b0;
        req_valid = 1'b0;
        xl("R10", 16'h0018, 32'h5, 2'd0, 2'd0, 3'd0, 32'h0000_0105);
    endtask

    task automatic t_stream;
        xl("R9", 16'h0010, 32'hA, 2'd0, 2'd0, 3'd0, 32'hA);
        xl("R9", 16'h0000, 32'hB, 2'd0, 2'd0, 3'd1, 32'h0);
        xl("R9", 16'h0010, 32'hC, 2'd0, 2'd0, 3'd0, 32'hC);
        @(posedge clk);
        #1;
        check("R9", "drain resp_valid", 32'(resp_valid), 32'd0);
        check("R9", "ready held", 32'(req_ready), 32'd1);
    endtask

    initial begin
        t_reset;
        t_setup;
        t_null;
        t_flat;
        t_wrap;
        t_limit;
        t_absent;
        t_type;
        t_priv;
        t_local;
        t_priority;
        t_collide;
        t_stream;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule